// File: doc/BRIEF.md
# Step-Table Tone Synthesizer

This block is a compact music source for a chip that needs a looping soundtrack and has no processor or memory to play one. A short track is held as a set of constant step entries inside the block. Each step gives three things: a pitch increment for a triangle-wave bass voice, a pitch increment for a square-wave key voice, and a small drum code. The track moves forward one step after a fixed number of sample ticks. When it reaches the last step it returns to the first, so the track repeats for as long as the chip runs.

The key voice has an amplitude envelope. The envelope jumps to full scale when a note starts and then fades one level per sample tick. The bass voice has no envelope. The drum is not a separate voice. A nonzero drum code loads a pitch boost into the bass oscillator, and that boost then runs down to zero. A low code gives a low thump and a higher code gives a sharper one. The two voices are added into an 8-bit sample. A pulse-width modulator running at the system clock turns that sample into a 1-bit stream, which a speaker or a simple RC filter can smooth back into sound.

Top module: `tone_synth`

## Requirements
- R1: While `rst` is high and right after it is released, `sample_o` is 0 and `pwm_o` is 0. Reset also clears the step index, the tick counter, both phase accumulators, the envelope and the drum boost.
- R2: Only a clock with `sample_tick` high changes any voice or sequencer state. The step index moves forward once every TICKS_PER_STEP ticks (default 8) and goes from STEPS-1 (default 15) back to 0. While `sample_tick` stays low, `sample_o` holds its value.
- R3: Step s is defined by two fields, lo = s mod 4 and hi = (s div 4) mod 4. Its bass increment is 4 + 2*hi. Its key increment is 0 when lo = 3 and 8 + 4*lo otherwise. Its drum code is 0 when lo is not 0. When lo = 0, the drum code is 2 if hi is odd and 1 if hi is even.
- R4: On each tick, the 8-bit bass phase grows by the current step's bass increment plus the drum boost, modulo 256. The bass voice equals phase[6:0] when phase bit 7 is 0. When phase bit 7 is 1, it equals the bitwise inverse of phase[6:0].
- R5: On each tick, the 8-bit key phase grows by the current step's key increment, modulo 256. The key voice equals the envelope when key-phase bit 7 is 1 and the current key increment has any bit set. In every other case it is 0.
- R6: On a tick that moves to a step whose key increment is nonzero, the envelope is loaded with 63. On any other tick it falls by 1, and it stays at 0 once it gets there.
- R7: On a tick that moves to a step with a nonzero drum code d, the drum boost is loaded with d*16. On any other tick it falls by 1, and it stays at 0 once it gets there.
- R8: `sample_o` is the bass voice plus the key voice. It shows the state left by a tick one clock after the edge that took the tick, and it never exceeds 190.
- R9: An 8-bit counter advances on every clock. `pwm_o` is high when that counter is below the sample. With a steady sample, `pwm_o` is high on exactly `sample_o` out of every 256 consecutive clocks, and it is never high while the sample is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_tick | input | 1 | One-clock strobe that advances the audio state by one sample |
| sample_o | output | 8 | Summed audio sample |
| pwm_o | output | 1 | 1-bit pulse-width-modulated audio |

## Verification
The state changes on the clock edge that sees `sample_tick` high, and `sample_o` shows that new state on the next edge. Each tick in the bench therefore lasts one clock, waits one more edge, and compares the sample 1 ns after that second edge against a reference model that the bench builds from R3 to R8. The PWM output comes from a register that sits one clock behind the sample. To allow for this, the bench holds the tick low, lets two clocks pass, and then counts the high cycles of `pwm_o` over a window of 256 clocks.

// File: rtl/tone_pkg.sv
package tone_pkg;

    localparam int PH_W   = 8;
    localparam int ENV_W  = 6;
    localparam int TRI_W  = PH_W - 1;
    localparam int SMP_W  = 8;
    localparam int INC_W  = 8;
    localparam int DRUM_W = 2;

    typedef struct packed {
        logic [INC_W-1:0]  bass;
        logic [INC_W-1:0]  key;
        logic [DRUM_W-1:0] drum;
    } step_t;

    // Track content, computed per step index (R3)
    function automatic step_t make_step(int unsigned idx);
        step_t       s;
        int unsigned lo;
        int unsigned hi;
        lo = idx % 4;
        hi = (idx / 4) % 4;
        s.bass = INC_W'(4 + 2 * hi);
        s.key  = (lo == 3) ? '0 : INC_W'(8 + 4 * lo);
        if (lo == 0) begin
            s.drum = (hi % 2 == 1) ? DRUM_W'(2) : DRUM_W'(1);
        end else begin
            s.drum = '0;
        end
        return s;
    endfunction

endpackage

// File: rtl/tone_seq.sv
module tone_seq
    import tone_pkg::*;
#(
    parameter int STEPS          = 16,
    parameter int TICKS_PER_STEP = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    output logic              adv_o,
    output logic [INC_W-1:0]  bass_o,
    output logic [INC_W-1:0]  key_o,
    output logic [INC_W-1:0]  nkey_o,
    output logic [DRUM_W-1:0] ndrum_o
);

    localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam int CNT_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TICKS_PER_STEP - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } seq_state_t;

    seq_state_t st_d, st_q;
    step_t      tbl [STEPS];
    logic [IDX_W-1:0] nidx;

    for (genvar g = 0; g < STEPS; g++) begin : g_tbl
        assign tbl[g] = make_step(g);
    end

    always_comb begin
        st_d  = st_q;
        nidx  = (st_q.idx == LAST_IDX) ? '0 : st_q.idx + 1'b1;
        adv_o = tick_i && (st_q.cnt == LAST_CNT);
        if (tick_i) begin
            if (st_q.cnt == LAST_CNT) begin
                st_d.cnt = '0;
                st_d.idx = nidx;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bass_o  = tbl[st_q.idx].bass;
    assign key_o   = tbl[st_q.idx].key;
    assign nkey_o  = tbl[nidx].key;
    assign ndrum_o = tbl[nidx].drum;

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick_i && st_q.idx == LAST_IDX && st_q.cnt == LAST_CNT) |=> (st_q.idx == '0)); // R2
    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick_i) |=> $stable(st_q)); // R2
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LAST_CNT); // R2

endmodule

// File: rtl/tone_voices.sv
module tone_voices
    import tone_pkg::*;
#(
    parameter int DRUM_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              adv_i,
    input  logic [INC_W-1:0]  bass_i,
    input  logic [INC_W-1:0]  key_i,
    input  logic [INC_W-1:0]  nkey_i,
    input  logic [DRUM_W-1:0] ndrum_i,
    output logic [SMP_W-1:0]  sample_o
);

    localparam int SMP_MAX = (2 ** TRI_W - 1) + (2 ** ENV_W - 1);

    typedef struct packed {
        logic [PH_W-1:0]  bph;
        logic [PH_W-1:0]  kph;
        logic [ENV_W-1:0] env;
        logic [INC_W-1:0] drum;
        logic [SMP_W-1:0] smp;
    } voice_state_t;

    voice_state_t vs_d, vs_q;
    logic [TRI_W-1:0] tri_v;
    logic [ENV_W-1:0] gate;
    logic [ENV_W-1:0] key_v;
    logic [ENV_W-1:0] env_dec;
    logic [INC_W-1:0] drum_dec;
    logic [INC_W-1:0] drum_load;

    always_comb begin
        vs_d      = vs_q;
        tri_v     = vs_q.bph[PH_W-1] ? ~vs_q.bph[PH_W-2:0] : vs_q.bph[PH_W-2:0];
        gate      = {ENV_W{|key_i}};
        key_v     = vs_q.kph[PH_W-1] ? (vs_q.env & gate) : '0;
        vs_d.smp  = SMP_W'(tri_v) + SMP_W'(key_v);
        env_dec   = (vs_q.env == '0) ? '0 : vs_q.env - 1'b1;
        drum_dec  = (vs_q.drum == '0) ? '0 : vs_q.drum - 1'b1;
        drum_load = INC_W'(ndrum_i) << DRUM_SHIFT;
        if (tick_i) begin
            vs_d.bph = vs_q.bph + bass_i + vs_q.drum;
            vs_d.kph = vs_q.kph + key_i;
            if (adv_i) begin
                vs_d.env  = (|nkey_i) ? '1 : env_dec;
                vs_d.drum = (ndrum_i != '0) ? drum_load : drum_dec;
            end else begin
                vs_d.env  = env_dec;
                vs_d.drum = drum_dec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) vs_q <= '0;
        else     vs_q <= vs_d;
    end

    assign sample_o = vs_q.smp;

    AST_ENV_DECAY: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !adv_i && vs_q.env != '0) |=> (vs_q.env == $past(vs_q.env) - 1'b1)); // R6
    AST_ENV_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (tick_i && adv_i && nkey_i != '0) |=> (vs_q.env == {ENV_W{1'b1}})); // R6
    AST_DRUM_LOAD: assert property (@(posedge clk) disable iff (rst)
        (tick_i && adv_i && ndrum_i != '0) |=> (vs_q.drum == (INC_W'($past(ndrum_i)) << DRUM_SHIFT))); // R7
    AST_VOICE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick_i) |=> ($stable(vs_q.bph) && $stable(vs_q.kph) && $stable(vs_q.env))); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(sample_o) <= SMP_MAX); // R8

endmodule

// File: rtl/tone_pwm.sv
module tone_pwm
    import tone_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] sample_i,
    output logic             pwm_o
);

    typedef struct packed {
        logic [SMP_W-1:0] cnt;
        logic             pwm;
    } pwm_state_t;

    pwm_state_t ps_d, ps_q;

    always_comb begin
        ps_d     = ps_q;
        ps_d.cnt = ps_q.cnt + 1'b1;
        ps_d.pwm = (ps_q.cnt < sample_i);
    end

    always_ff @(posedge clk) begin
        if (rst) ps_q <= '0;
        else     ps_q <= ps_d;
    end

    assign pwm_o = ps_q.pwm;

    AST_PWM_SILENT: assert property (@(posedge clk) disable iff (rst)
        (sample_i == '0) |=> !pwm_o); // R9
    AST_PWM_FULL_CNT: assert property (@(posedge clk) disable iff (rst)
        (ps_q.cnt == '1) |=> (ps_q.cnt == '0)); // R9

endmodule

// File: rtl/tone_synth.sv
module tone_synth
    import tone_pkg::*;
#(
    parameter int STEPS          = 16,
    parameter int TICKS_PER_STEP = 8,
    parameter int DRUM_SHIFT     = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_tick,
    output logic [7:0] sample_o,
    output logic       pwm_o
);

    logic              adv;
    logic [INC_W-1:0]  bass_inc;
    logic [INC_W-1:0]  key_inc;
    logic [INC_W-1:0]  nkey_inc;
    logic [DRUM_W-1:0] ndrum;
    logic [SMP_W-1:0]  smp;

    tone_seq #(
        .STEPS          (STEPS),
        .TICKS_PER_STEP (TICKS_PER_STEP)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (sample_tick),
        .adv_o   (adv),
        .bass_o  (bass_inc),
        .key_o   (key_inc),
        .nkey_o  (nkey_inc),
        .ndrum_o (ndrum)
    );

    tone_voices #(
        .DRUM_SHIFT (DRUM_SHIFT)
    ) u_voices (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (sample_tick),
        .adv_i    (adv),
        .bass_i   (bass_inc),
        .key_i    (key_inc),
        .nkey_i   (nkey_inc),
        .ndrum_i  (ndrum),
        .sample_o (smp)
    );

    tone_pwm u_pwm (
        .clk      (clk),
        .rst      (rst),
        .sample_i (smp),
        .pwm_o    (pwm_o)
    );

    assign sample_o = smp;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (sample_o == 8'd0 && !pwm_o)); // R1

endmodule

// File: tb/sim_tone_synth.sv
`timescale 1ns/1ps
module sim_tone_synth;

    localparam int STEPS = 16;
    localparam int TPS   = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_tick = 1'b0;
    logic [7:0] sample_o;
    logic       pwm_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    int m_step, m_cnt, m_bph, m_kph, m_env, m_drum, m_exp;

    always #2 clk = ~clk;

    tone_synth #(.STEPS(STEPS), .TICKS_PER_STEP(TPS), .DRUM_SHIFT(4)) u0 (
        .clk         (clk),
        .rst         (rst),
        .sample_tick (sample_tick),
        .sample_o    (sample_o),
        .pwm_o       (pwm_o)
    );

    function automatic int f_bass(int s);
        return 4 + 2 * ((s / 4) % 4);
    endfunction
    function automatic int f_key(int s);
        return ((s % 4) == 3) ? 0 : 8 + 4 * (s % 4);
    endfunction
    function automatic int f_drum(int s);
        if ((s % 4) != 0) return 0;
        return (((s / 4) % 4) % 2 == 1) ? 2 : 1;
    endfunction

    function automatic int f_expect();
        int tri_v, key_v;
        tri_v = (m_bph >= 128) ? (127 - (m_bph % 128)) : m_bph;
        key_v = (m_kph >= 128 && f_key(m_step) != 0) ? m_env : 0;
        return tri_v + key_v;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // returns 1 when this tick moved to a new step
    task automatic do_tick(output bit advanced);
        int bv, kv, nk, nd;
        @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        bv = f_bass(m_step);
        kv = f_key(m_step);
        m_bph = (m_bph + bv + m_drum) % 256;
        m_kph = (m_kph + kv) % 256;
        advanced = (m_cnt == TPS - 1);
        if (advanced) begin
            m_cnt  = 0;
            m_step = (m_step + 1) % STEPS;
            nk = f_key(m_step);
            nd = f_drum(m_step);
            m_env  = (nk != 0) ? 63 : ((m_env > 0) ? m_env - 1 : 0);
            m_drum = (nd != 0) ? nd * 16 : ((m_drum > 0) ? m_drum - 1 : 0);
        end else begin
            m_cnt++;
            m_env  = (m_env > 0) ? m_env - 1 : 0;
            m_drum = (m_drum > 0) ? m_drum - 1 : 0;
        end
        m_exp = f_expect();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        sample_tick = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk("R1 sample in reset", int'(sample_o), 0);
        chk("R1 pwm in reset", int'(pwm_o), 0);
        @(negedge clk);
        rst = 1'b0;
        m_step = 0; m_cnt = 0; m_bph = 0; m_kph = 0; m_env = 0; m_drum = 0; m_exp = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 sample after reset", int'(sample_o), 0);
        chk("R1 pwm after reset", int'(pwm_o), 0);
    endtask

    task automatic t_first_step();
        bit adv;
        for (int i = 0; i < TPS - 1; i++) begin
            do_tick(adv);
            chk("R4 bass-only sample before first note", int'(sample_o), m_exp);
        end
    endtask

    task automatic t_note_start();
        bit adv;
        do_tick(adv);
        chk("R6 step boundary reached", int'(adv), 1);
        chk("R6 sample at note start", int'(sample_o), m_exp);
        do_tick(adv);
        chk("R7 sample with drum boost", int'(sample_o), m_exp);
    endtask

    task automatic t_idle();
        int held;
        held = int'(sample_o);
        repeat (20) @(posedge clk);
        #1;
        chk("R2 sample held without tick", int'(sample_o), held);
        chk("R2 held sample matches model", int'(sample_o), m_exp);
    endtask

    task automatic t_loop(int n);
        bit adv;
        string tag;
        for (int i = 0; i < n; i++) begin
            do_tick(adv);
            if (adv)                      tag = "R2 sample after step advance";
            else if (m_drum != 0)         tag = "R7 sample during drum decay";
            else if (f_key(m_step) == 0)  tag = "R5 sample with key gated off";
            else if (m_env == 0)          tag = "R6 sample with envelope floored";
            else                          tag = "R3 sample from step table";
            chk(tag, int'(sample_o), m_exp);
        end
        chk("R8 sample sum after loop", int'(sample_o), m_exp);
    endtask

    task automatic t_pwm();
        int highs;
        int smp;
        repeat (2) @(posedge clk);
        #1;
        smp = int'(sample_o);
        highs = 0;
        for (int i = 0; i < 256; i++) begin
            @(posedge clk);
            #1;
            if (pwm_o) highs++;
        end
        chk("R9 pwm duty equals sample", highs, smp);
    endtask

    task automatic t_pwm_silent();
        int highs;
        t_reset();
        highs = 0;
        for (int i = 0; i < 256; i++) begin
            @(posedge clk);
            #1;
            if (pwm_o) highs++;
        end
        chk("R9 pwm silent for zero sample", highs, 0);
    endtask

    initial begin
        #600000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_first_step();
        t_note_start();
        t_idle();
        t_pwm();
        t_loop(STEPS * TPS + 5);
        t_idle();
        t_pwm();
        t_loop(37);
        t_pwm();
        t_pwm_silent();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule